// File: doc/BRIEF.md
# Scrambling Enable Sequencer

This block makes the link-setup decision about TMDS scrambling in a display transmitter. On a start pulse it takes a snapshot of the pixel clock (in kHz), the transmitter revision, the software scrambling request and the precomputed status timeout. It then runs one of three paths. If the revision is too old, it skips the operation. If scrambling is needed, it runs an ordered enable. Otherwise it runs a single-write disable.

Sink register writes go out through a request/acknowledge port. A request carries a register id and a data byte, and the acknowledge comes back with an error flag. An external transport (the DDC bus master) answers these requests. The block also drives two local datapath control bits. It keeps a status watchdog that counts horizontal sync strobes after a successful enable and flags a timeout if the sink never confirms scrambling.

Top module: `scr_enable_seq`

## Requirements
- R1: If the transmitter revision is below `MIN_TX_VER`, the run ends with a single `done` pulse. It makes no sink request, does not raise `error` and changes no control bit.
- R2: A pixel clock strictly greater than `RATE_LIMIT_KHZ` (340000) forces the enable path and uses bit-clock ratio data 1. At or below the limit the ratio data is 0, and the enable path is taken only when `scr_req` is high.
- R3: The enable path runs in a fixed order. First comes a write to register id `RATIO_REG` (0) with the ratio. Next, `ctl_update` and `ctl_scr_en` go high. Last comes a write of 1 to register id `SCR_REG` (1), issued only once both control bits are high.
- R4: An error on the ratio write ends the run with `error` high. No enable write follows, both control bits stay low and `scr_enabled` stays low.
- R5: An error on the enable write ends the run with `error` high and `scr_enabled` low.
- R6: A successful enable sets `scr_enabled` and arms the status timer (`tmr_armed` high) with `tmr_count` equal to the supplied timeout.
- R7: A supplied timeout that is zero or negative loads `DEFAULT_TMO` instead.
- R8: The disable path writes 0 to register id `SCR_REG`. It clears `scr_enabled` and disarms the timer, and it leaves `error` low even if that write reports an error.
- R9: While armed, each `hsync` decrements `tmr_count`. The strobe that would take the count to zero gives a one-cycle `timeout` pulse and disarms the timer. A `status_ok` pulse disarms the timer with no timeout.
- R10: `done` is high for exactly one cycle at the end of every path, and a `start` that arrives while a run is in progress is ignored.
- R11: While `sink_req` is high and not yet acknowledged, `sink_reg` and `sink_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (one-cycle pulse) |
| pix_khz | input | PIX_W | Pixel clock frequency in kHz |
| tx_ver | input | VER_W | Transmitter revision |
| scr_req | input | 1 | Software scrambling request |
| tmo_hsync | input | TMO_W | Signed status timeout in hsync periods |
| hsync | input | 1 | One-cycle strobe per line |
| status_ok | input | 1 | Sink reported scrambling active |
| sink_req | output | 1 | Sink register write request |
| sink_reg | output | REG_W | Register id of the write |
| sink_data | output | DATA_W | Data of the write |
| sink_ack | input | 1 | Write completed (one cycle) |
| sink_err | input | 1 | Write failed, valid with `sink_ack` |
| ctl_update | output | 1 | Local datapath-mode update bit |
| ctl_scr_en | output | 1 | Local scrambler enable bit |
| tmr_armed | output | 1 | Status timer running |
| tmr_count | output | TMO_W-1 | Remaining hsync periods |
| timeout | output | 1 | Status timer expired (one cycle) |
| done | output | 1 | Sequence finished (one cycle) |
| error | output | 1 | Last sequence aborted on a write error |
| scr_enabled | output | 1 | Scrambling confirmed enabled |

## Verification
The bench builds the block with `TMO_W` of 16, `MIN_TX_VER` of 4 and `DEFAULT_TMO` of 50. A short fallback value keeps the loaded count easy to tell apart from supplied values such as 100 or 7. A signed timeout of 16 bits makes it simple to drive zero and negative values. The 340000 kHz threshold is exercised exactly at the limit and one kHz above it. Timeouts of 3 lines let expiry and early confirmation be checked in a handful of strobes. A delayed acknowledge keeps requests pending long enough to hit them with stray start pulses.

// File: rtl/scr_enable_seq.sv
module scr_enable_seq #(
  parameter int PIX_W          = 20,
  parameter int VER_W          = 8,
  parameter int TMO_W          = 20,
  parameter int MIN_TX_VER     = 4,
  parameter int RATE_LIMIT_KHZ = 340000,
  parameter int DEFAULT_TMO    = 1000,
  parameter int REG_W          = 2,
  parameter int DATA_W         = 8,
  parameter int RATIO_REG      = 0,
  parameter int SCR_REG        = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [PIX_W-1:0]        pix_khz,
  input  logic [VER_W-1:0]        tx_ver,
  input  logic                    scr_req,
  input  logic signed [TMO_W-1:0] tmo_hsync,
  input  logic                    hsync,
  input  logic                    status_ok,
  output logic                    sink_req,
  output logic [REG_W-1:0]        sink_reg,
  output logic [DATA_W-1:0]       sink_data,
  input  logic                    sink_ack,
  input  logic                    sink_err,
  output logic                    ctl_update,
  output logic                    ctl_scr_en,
  output logic                    tmr_armed,
  output logic [TMO_W-2:0]        tmr_count,
  output logic                    timeout,
  output logic                    done,
  output logic                    error,
  output logic                    scr_enabled
);
  localparam int CNT_W = TMO_W - 1;

  typedef enum logic [2:0] {S_IDLE, S_RATIO, S_CTL, S_ENA, S_ARM, S_DIS, S_FIN} st_t;

  st_t              state;
  logic             ratio_q;
  logic [CNT_W-1:0] load_q;

  wire ver_ok = tx_ver >= VER_W'(MIN_TX_VER);
  wire fast   = pix_khz > PIX_W'(RATE_LIMIT_KHZ);
  wire want   = fast | scr_req;
  wire [CNT_W-1:0] load_val = (tmo_hsync > 0) ? tmo_hsync[CNT_W-1:0] : CNT_W'(DEFAULT_TMO);

  assign sink_req  = (state == S_RATIO) || (state == S_ENA) || (state == S_DIS);
  assign sink_reg  = (state == S_RATIO) ? REG_W'(RATIO_REG) : REG_W'(SCR_REG);
  assign sink_data = (state == S_RATIO) ? DATA_W'(ratio_q) :
                     (state == S_ENA)   ? DATA_W'(1) : '0;
  assign done      = (state == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      ratio_q     <= 1'b0;
      load_q      <= '0;
      error       <= 1'b0;
      scr_enabled <= 1'b0;
      ctl_update  <= 1'b0;
      ctl_scr_en  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          error   <= 1'b0;
          ratio_q <= fast;
          load_q  <= load_val;
          state   <= !ver_ok ? S_FIN : (want ? S_RATIO : S_DIS);
        end
        S_RATIO: if (sink_ack) begin
          if (sink_err) begin
            error <= 1'b1;
            state <= S_FIN;
          end else begin
            state <= S_CTL;
          end
        end
        S_CTL: begin
          ctl_update <= 1'b1;
          ctl_scr_en <= 1'b1;
          state      <= S_ENA;
        end
        S_ENA: if (sink_ack) begin
          if (sink_err) begin
            error       <= 1'b1;
            scr_enabled <= 1'b0;
            state       <= S_FIN;
          end else begin
            scr_enabled <= 1'b1;
            state       <= S_ARM;
          end
        end
        S_ARM: state <= S_FIN;
        S_DIS: if (sink_ack) begin
          scr_enabled <= 1'b0;
          state       <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  wire arm_load = (state == S_ARM);
  wire dis_done = (state == S_DIS) && sink_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_armed <= 1'b0;
      tmr_count <= '0;
      timeout   <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (arm_load) begin
        tmr_armed <= 1'b1;
        tmr_count <= load_q;
      end else if (dis_done) begin
        tmr_armed <= 1'b0;
        tmr_count <= '0;
      end else if (tmr_armed) begin
        if (status_ok) begin
          tmr_armed <= 1'b0;
          tmr_count <= '0;
        end else if (hsync) begin
          if (tmr_count <= CNT_W'(1)) begin
            tmr_armed <= 1'b0;
            tmr_count <= '0;
            timeout   <= 1'b1;
          end else begin
            tmr_count <= tmr_count - CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/scr_enable_seq_chk.sv
module scr_enable_seq_chk #(
  parameter int REG_W   = 2,
  parameter int DATA_W  = 8,
  parameter int SCR_REG = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sink_req,
  input logic              sink_ack,
  input logic [REG_W-1:0]  sink_reg,
  input logic [DATA_W-1:0] sink_data,
  input logic              ctl_update,
  input logic              ctl_scr_en,
  input logic              tmr_armed,
  input logic              timeout,
  input logic              done,
  input logic              error,
  input logic              scr_enabled
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sink_req && !sink_ack |=> sink_req && $stable(sink_reg) && $stable(sink_data)); // R11
  AST_ENA_AFTER_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    sink_req && sink_reg == REG_W'(SCR_REG) && sink_data == DATA_W'(1) |-> ctl_scr_en && ctl_update); // R3
  AST_ON_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) $rose(scr_enabled) |-> !error); // R5
  AST_ON_ARMS: assert property (@(posedge clk) disable iff (!rst_n) $rose(scr_enabled) |=> tmr_armed); // R6
  AST_TMO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) timeout |=> !timeout); // R9
  AST_TMO_DISARM: assert property (@(posedge clk) disable iff (!rst_n) $rose(timeout) |-> !tmr_armed); // R9
endmodule

bind scr_enable_seq scr_enable_seq_chk #(.REG_W(REG_W), .DATA_W(DATA_W), .SCR_REG(SCR_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sink_req(sink_req), .sink_ack(sink_ack),
  .sink_reg(sink_reg), .sink_data(sink_data), .ctl_update(ctl_update),
  .ctl_scr_en(ctl_scr_en), .tmr_armed(tmr_armed), .timeout(timeout),
  .done(done), .error(error), .scr_enabled(scr_enabled)
);

// File: tb/scr_enable_seq_bench.sv
module scr_enable_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 20;
  localparam int VER_W = 8;
  localparam int TMO_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, scr_req = 1'b0;
  logic hsync = 1'b0, status_ok = 1'b0, sink_ack = 1'b0, sink_err = 1'b0;
  logic [PIX_W-1:0] pix_khz = '0;
  logic [VER_W-1:0] tx_ver = '0;
  logic signed [TMO_W-1:0] tmo_hsync = '0;
  logic sink_req, ctl_update, ctl_scr_en, tmr_armed, timeout, done, error, scr_enabled;
  logic [1:0] sink_reg;
  logic [7:0] sink_data;
  logic [TMO_W-2:0] tmr_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  scr_enable_seq #(.PIX_W(PIX_W), .VER_W(VER_W), .TMO_W(TMO_W), .MIN_TX_VER(4),
                   .RATE_LIMIT_KHZ(340000), .DEFAULT_TMO(50)) u_scr_enable_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_khz(pix_khz), .tx_ver(tx_ver),
    .scr_req(scr_req), .tmo_hsync(tmo_hsync), .hsync(hsync), .status_ok(status_ok),
    .sink_req(sink_req), .sink_reg(sink_reg), .sink_data(sink_data),
    .sink_ack(sink_ack), .sink_err(sink_err), .ctl_update(ctl_update),
    .ctl_scr_en(ctl_scr_en), .tmr_armed(tmr_armed), .tmr_count(tmr_count),
    .timeout(timeout), .done(done), .error(error), .scr_enabled(scr_enabled));

  int n_chk = 0, n_bad = 0;
  int nwr, ndone;
  int wreg [4];
  int wdat [4];
  int wctl [4];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input int pix, input int ver, input logic req, input int tmo,
                     input logic er, input logic ee, input int dly, input logic poke);
    int waited = 0;
    pix_khz = PIX_W'(pix); tx_ver = VER_W'(ver); scr_req = req; tmo_hsync = TMO_W'(tmo);
    nwr = 0; ndone = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 40; c++) begin
      sink_ack = 1'b0; sink_err = 1'b0;
      if (sink_req) begin
        if (waited < dly) begin
          waited++;
          if (poke) start = 1'b1;
        end else begin
          if (nwr < 4) begin
            wreg[nwr] = int'(sink_reg); wdat[nwr] = int'(sink_data); wctl[nwr] = int'(ctl_scr_en);
          end
          nwr++;
          waited = 0;
          sink_ack = 1'b1;
          sink_err = (sink_reg == 2'd0) ? er : ee;
        end
      end
      if (done) ndone++;
      @(negedge clk);
      start = 1'b0;
    end
    chk("R10 done pulses per run", ndone, 1);
  endtask

  task automatic hs();
    hsync = 1'b1; @(negedge clk); hsync = 1'b0;
  endtask

  typedef struct packed {
    logic [19:0] pix; logic [7:0] ver; logic req; logic signed [15:0] tmo;
    logic er; logic ee; logic [3:0] dly;
    logic [2:0] nwr; logic [7:0] d0; logic [7:0] r1; logic [7:0] d1;
    logic xerr; logic xen; logic xctl; logic [15:0] xcnt;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{20'd400000, 8'd3, 1'b1, 16'sd100, 1'b0, 1'b0, 4'd0, 3'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 16'd0},
    '{20'd340000, 8'd4, 1'b0, 16'sd100, 1'b0, 1'b0, 4'd0, 3'd1, 8'd0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 16'd0},
    '{20'd340001, 8'd4, 1'b0, 16'sd100, 1'b0, 1'b0, 4'd0, 3'd2, 8'd1, 8'd1, 8'd1, 1'b0, 1'b1, 1'b1, 16'd100},
    '{20'd200000, 8'd5, 1'b1, 16'sd0,   1'b0, 1'b0, 4'd0, 3'd2, 8'd0, 8'd1, 8'd1, 1'b0, 1'b1, 1'b1, 16'd50},
    '{20'd200000, 8'd4, 1'b1, -16'sd5,  1'b0, 1'b0, 4'd0, 3'd2, 8'd0, 8'd1, 8'd1, 1'b0, 1'b1, 1'b1, 16'd50},
    '{20'd100000, 8'd4, 1'b0, 16'sd9,   1'b0, 1'b1, 4'd0, 3'd1, 8'd0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 16'd0},
    '{20'd500000, 8'd4, 1'b0, 16'sd9,   1'b1, 1'b0, 4'd0, 3'd1, 8'd1, 8'd0, 8'd0, 1'b1, 1'b0, 1'b0, 16'd0},
    '{20'd350000, 8'd4, 1'b1, 16'sd9,   1'b0, 1'b1, 4'd0, 3'd2, 8'd1, 8'd1, 8'd1, 1'b1, 1'b0, 1'b1, 16'd0},
    '{20'd100000, 8'd4, 1'b1, 16'sd7,   1'b0, 1'b0, 4'd3, 3'd2, 8'd0, 8'd1, 8'd1, 1'b0, 1'b1, 1'b1, 16'd7}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit saw;
    do_reset();
    chk("reset done", int'(done), 0);
    chk("reset error", int'(error), 0);
    chk("reset scr_enabled", int'(scr_enabled), 0);
    chk("reset sink_req", int'(sink_req), 0);
    chk("reset ctl", int'(ctl_update | ctl_scr_en), 0);
    chk("reset armed", int'(tmr_armed), 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      run(int'(VEC[i].pix), int'(VEC[i].ver), VEC[i].req, int'(VEC[i].tmo),
          VEC[i].er, VEC[i].ee, int'(VEC[i].dly), 1'b0);
      chk("R1 R2 write count", nwr, int'(VEC[i].nwr));
      if (VEC[i].nwr == 2) begin
        chk("R3 first write ratio reg", wreg[0], 0);
        chk("R2 ratio data", wdat[0], int'(VEC[i].d0));
        chk("R3 ctl low at ratio write", wctl[0], 0);
        chk("R3 second write enable reg", wreg[1], int'(VEC[i].r1));
        chk("R3 enable data", wdat[1], int'(VEC[i].d1));
        chk("R3 ctl high at enable write", wctl[1], 1);
      end else if (VEC[i].nwr == 1) begin
        chk("R4 R8 single write reg", wreg[0], VEC[i].er ? 0 : 1);
        chk("R2 R8 single write data", wdat[0], int'(VEC[i].d0));
      end
      chk("R4 R5 R8 error", int'(error), int'(VEC[i].xerr));
      chk("R5 R6 scr_enabled", int'(scr_enabled), int'(VEC[i].xen));
      chk("R3 R4 ctl_scr_en", int'(ctl_scr_en), int'(VEC[i].xctl));
      chk("R1 ctl_update", int'(ctl_update), int'(VEC[i].xctl));
      chk("R6 R7 tmr_count", int'(tmr_count), int'(VEC[i].xcnt));
      chk("R6 tmr_armed", int'(tmr_armed), int'(VEC[i].xen));
    end

    do_reset();
    run(200000, 4, 1'b1, 3, 1'b0, 1'b0, 0, 1'b0);
    hs(); hs();
    chk("R9 count after two strobes", int'(tmr_count), 1);
    chk("R9 still armed", int'(tmr_armed), 1);
    chk("R9 no early timeout", int'(timeout), 0);
    hs();
    chk("R9 timeout pulse", int'(timeout), 1);
    chk("R9 disarmed", int'(tmr_armed), 0);
    @(negedge clk);
    chk("R9 timeout one cycle", int'(timeout), 0);

    do_reset();
    run(200000, 4, 1'b1, 3, 1'b0, 1'b0, 0, 1'b0);
    status_ok = 1'b1; @(negedge clk); status_ok = 1'b0;
    saw = 0;
    for (int k = 0; k < 4; k++) begin hs(); if (timeout) saw = 1; end
    chk("R9 status_ok suppresses timeout", int'(saw), 0);
    chk("R9 status_ok disarms", int'(tmr_armed), 0);

    do_reset();
    run(400000, 4, 1'b0, 20, 1'b0, 1'b0, 0, 1'b0);
    chk("R8 enabled before disable", int'(scr_enabled), 1);
    run(100000, 4, 1'b0, 20, 1'b0, 1'b1, 0, 1'b0);
    chk("R8 disable clears scr_enabled", int'(scr_enabled), 0);
    chk("R8 disable disarms", int'(tmr_armed), 0);
    chk("R8 disable error ignored", int'(error), 0);

    do_reset();
    run(100000, 4, 1'b1, 12, 1'b0, 1'b0, 4, 1'b1);
    chk("R10 stray start write count", nwr, 2);
    chk("R10 stray start enabled", int'(scr_enabled), 1);
    chk("R11 held request completed", int'(tmr_count), 12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule